// File: doc/BRIEF.md
# Over-Discharge Guard Sequencer

This block sequences a battery monitor through its over-discharge protection mode. While the pack is deeply discharged and the supply is low, the block sleeps. In sleep it turns off the regulator, closes the serial access port and holds both power switches open. When a charger brings the supply back above the wake level, the block restores the regulator and serial access. It then runs a fixed settling window during which it ignores writes to the switch control bits. After that it enters a guarded state. It stays in that state until a release countdown shows that the cells have stayed above the release level.

The release check has two variants, chosen at run time by the monitor-channel select field. With a channel selected, the block returns to normal operation as soon as the countdown ends with the cells still good. With no channel selected, the end of the countdown is only the first sample. A second sample, taken a fixed number of ticks later, must also show good cells; if it does not, the countdown starts again. While the block is guarded, the discharge switch stays open even after software has set its control bit. The bit is kept and takes effect on release. The charge switch follows only its own control bit. A charge-enable input opens both switches at once, whatever the bits hold. In normal operation a low supply no longer puts the block to sleep. An under-voltage trip returns it to the guarded state.

All flags arrive already digitised and synchronous to the clock. Time is counted in pulses of a millisecond tick input, and every duration is a parameter.

Top module: `cell_guard_seq`

## Requirements
- R1: Out of reset the block is asleep (`asleep`=1, `prot_mode`=1). While asleep, `reg_en`, `spi_en`, `chg_fet` and `dsg_fet` are all 0.
- R2: When `wake_ok` is 1 during a clock edge while asleep, the block enters the settling window after that edge. `win_busy`, `reg_en` and `spi_en` go to 1 and `prot_mode` stays 1.
- R3: The settling window counts W = max(WIN_A_TICKS, WIN_B_TICKS) + WIN_PAD_TICKS ticks. It ends on the first edge after the count reaches zero, so with the tick held high `win_busy` is 1 for W+1 cycles. Control-bit writes made while asleep or in the window are discarded, and `chg_fet` is 0 during the window.
- R4: While `prot_mode` is 1, `dsg_fet` is 0. A `wr_dsg` write in the guarded state is stored and drives `dsg_fet` after release.
- R5: In the guarded state the release counter is loaded with REL_TICKS. It decrements on ticks only while `cells_ok` is 1 and reloads on any cycle in which `cells_ok` is 0.
- R6: If `mon_sel` is non-zero when the counter reaches zero with `cells_ok` high, the next edge enters normal operation (`prot_mode`=0). With the tick held high and good cells from the start, this takes REL_TICKS+1 edges.
- R7: If `mon_sel` is all zeros, reaching zero is the first sample. After GAP_TICKS further ticks, `cells_ok` is sampled again; `cells_ok` between the two samples is ignored. If the second sample is 1 the block releases; if it is 0 the counter reloads and counting resumes.
- R8: In the guarded state (after the window), `wake_ok` at 0 on an edge puts the block to sleep. In the window, `wake_ok` at 0 also returns it to sleep.
- R9: In normal operation, `wake_ok` has no effect on the mode.
- R10: `chg_fet` is 1 only when a 1 has been written with `wr_chg` in the guarded or normal state, `chg_en` is 1, and the block is guarded or normal. Release does not change it.
- R11: `chg_en` at 0 forces `chg_fet` and `dsg_fet` to 0 in the same cycle. The control bits keep their values.
- R12: `uv_trip` at 1 on an edge in normal operation returns the block to the guarded state, with `dsg_fet` at 0 and the release counter reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond time base pulse |
| wake_ok | input | 1 | Supply above the wake threshold |
| cells_ok | input | 1 | All cells above the under-voltage release level |
| chg_en | input | 1 | Charge enable; 0 opens both switches |
| uv_trip | input | 1 | Under-voltage detected in normal operation |
| mon_sel | input | MON_W | Monitor channel select; zero selects two-sample recovery |
| wr_chg | input | 1 | Write strobe for the charge control bit |
| wr_dsg | input | 1 | Write strobe for the discharge control bit |
| wr_data | input | 1 | Value written by either strobe |
| chg_fet | output | 1 | Charge switch gate enable |
| dsg_fet | output | 1 | Discharge switch gate enable |
| reg_en | output | 1 | Regulator enable |
| spi_en | output | 1 | Serial access enable |
| prot_mode | output | 1 | Over-discharge protection active |
| asleep | output | 1 | Sleep state |
| win_busy | output | 1 | Post-wake settling window active |

## Verification
The properties assume that every flag input has already been synchronised to `clk` and changes at most once per cycle. They also assume that `uv_trip` is raised only by a real under-voltage event, so a normal state with no trip is expected to persist. The stimulus changes inputs only on the falling clock edge and holds them for whole cycles. It also drives the tick either high continuously or as isolated one-cycle pulses, which are the two time-base shapes the block is built for.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;

  typedef enum logic [1:0] {
    CG_SLEEP  = 2'd0,
    CG_WINDOW = 2'd1,
    CG_GUARD  = 2'd2,
    CG_NORMAL = 2'd3
  } cg_state_e;

  typedef enum logic {
    PH_COUNT = 1'b0,
    PH_SPACE = 1'b1
  } cg_phase_e;

  function automatic int unsigned cg_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cg_down_cnt.sv
module cg_down_cnt #(
  parameter int unsigned LOAD_VAL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  localparam int unsigned W = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);
  localparam logic [W-1:0] INIT = W'(LOAD_VAL);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= INIT;
    else if (load)                cnt_q <= INIT;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cg_release.sv
module cg_release
  import cell_guard_pkg::*;
#(
  parameter int unsigned REL_TICKS = 2000,
  parameter int unsigned GAP_TICKS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic cells_ok,
  input  logic single_shot,
  output logic release_o
);
  cg_phase_e phase_q;
  logic counting;
  logic rel_zero, gap_zero;
  logic rel_load, rel_dec, gap_load, gap_dec;

  assign counting = (phase_q == PH_COUNT);

  assign rel_load = !active
                  || (counting && !cells_ok)
                  || (!counting && gap_zero && !cells_ok);
  assign rel_dec  = active && counting && cells_ok && tick;
  assign gap_load = !active || counting;
  assign gap_dec  = active && !counting && tick;

  cg_down_cnt #(.LOAD_VAL(REL_TICKS)) u_rel_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rel_load),
    .dec  (rel_dec),
    .zero (rel_zero)
  );

  cg_down_cnt #(.LOAD_VAL(GAP_TICKS)) u_gap_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (gap_load),
    .dec  (gap_dec),
    .zero (gap_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                             phase_q <= PH_COUNT;
    else if (!active)                                       phase_q <= PH_COUNT;
    else if (counting && cells_ok && rel_zero && !single_shot) phase_q <= PH_SPACE;
    else if (!counting && gap_zero)                         phase_q <= PH_COUNT;
  end

  assign release_o = active && cells_ok &&
                     ((counting && rel_zero && single_shot) || (!counting && gap_zero));
endmodule

// File: rtl/cg_fet_ctrl.sv
module cg_fet_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_open,
  input  logic wr_chg,
  input  logic wr_dsg,
  input  logic wr_data,
  input  logic chg_en,
  input  logic chg_allow,
  input  logic dsg_allow,
  output logic chg_fet,
  output logic dsg_fet
);
  logic chg_bit_q, dsg_bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_bit_q <= 1'b0;
      dsg_bit_q <= 1'b0;
    end else if (wr_open) begin
      if (wr_chg) chg_bit_q <= wr_data;
      if (wr_dsg) dsg_bit_q <= wr_data;
    end
  end

  assign chg_fet = chg_bit_q && chg_en && chg_allow;
  assign dsg_fet = dsg_bit_q && chg_en && dsg_allow;
endmodule

// File: rtl/cell_guard_seq.sv
module cell_guard_seq
  import cell_guard_pkg::*;
#(
  parameter int unsigned REL_TICKS     = 2000,
  parameter int unsigned GAP_TICKS     = 120,
  parameter int unsigned WIN_A_TICKS   = 1000,
  parameter int unsigned WIN_B_TICKS   = 500,
  parameter int unsigned WIN_PAD_TICKS = 200,
  parameter int unsigned MON_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             wake_ok,
  input  logic             cells_ok,
  input  logic             chg_en,
  input  logic             uv_trip,
  input  logic [MON_W-1:0] mon_sel,
  input  logic             wr_chg,
  input  logic             wr_dsg,
  input  logic             wr_data,
  output logic             chg_fet,
  output logic             dsg_fet,
  output logic             reg_en,
  output logic             spi_en,
  output logic             prot_mode,
  output logic             asleep,
  output logic             win_busy
);
  localparam int unsigned WIN_TICKS = cg_max(WIN_A_TICKS, WIN_B_TICKS) + WIN_PAD_TICKS;

  cg_state_e state_q, state_d;
  logic in_sleep, in_window, in_guard, in_normal;
  logic win_zero, rel_fire, mon_any, win_dec, ctl_open;

  assign in_sleep  = (state_q == CG_SLEEP);
  assign in_window = (state_q == CG_WINDOW);
  assign in_guard  = (state_q == CG_GUARD);
  assign in_normal = (state_q == CG_NORMAL);
  assign mon_any   = |mon_sel;
  assign win_dec   = in_window && ms_tick;
  assign ctl_open  = in_guard || in_normal;

  cg_down_cnt #(.LOAD_VAL(WIN_TICKS)) u_win_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (in_sleep),
    .dec  (win_dec),
    .zero (win_zero)
  );

  cg_release #(.REL_TICKS(REL_TICKS), .GAP_TICKS(GAP_TICKS)) u_release (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (in_guard),
    .tick       (ms_tick),
    .cells_ok   (cells_ok),
    .single_shot(mon_any),
    .release_o  (rel_fire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CG_SLEEP:  if (wake_ok) state_d = CG_WINDOW;
      CG_WINDOW: begin
        if (!wake_ok)     state_d = CG_SLEEP;
        else if (win_zero) state_d = CG_GUARD;
      end
      CG_GUARD: begin
        if (!wake_ok)     state_d = CG_SLEEP;
        else if (rel_fire) state_d = CG_NORMAL;
      end
      CG_NORMAL: if (uv_trip) state_d = CG_GUARD;
      default:   state_d = CG_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CG_SLEEP;
    else        state_q <= state_d;
  end

  cg_fet_ctrl u_fet (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_open  (ctl_open),
    .wr_chg   (wr_chg),
    .wr_dsg   (wr_dsg),
    .wr_data  (wr_data),
    .chg_en   (chg_en),
    .chg_allow(ctl_open),
    .dsg_allow(in_normal),
    .chg_fet  (chg_fet),
    .dsg_fet  (dsg_fet)
  );

  assign reg_en    = !in_sleep;
  assign spi_en    = !in_sleep;
  assign prot_mode = !in_normal;
  assign asleep    = in_sleep;
  assign win_busy  = in_window;
endmodule

// File: rtl/cg_seq_chk.sv
module cg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wake_ok,
  input logic uv_trip,
  input logic chg_en,
  input logic chg_fet,
  input logic dsg_fet,
  input logic reg_en,
  input logic spi_en,
  input logic prot_mode,
  input logic asleep,
  input logic win_busy
);
  // R1
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!reg_en && !spi_en && !chg_fet && !dsg_fet));

  // R2
  wake_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_ok) |=> (win_busy && reg_en && spi_en && prot_mode));

  // R3
  window_chg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy |-> !chg_fet);

  // R4
  guard_dsg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_mode |-> !dsg_fet);

  // R8
  guard_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode && !asleep && !wake_ok) |=> asleep);

  // R9
  normal_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_mode && !uv_trip) |=> !prot_mode);

  // R11
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |-> (!chg_fet && !dsg_fet));

  // R12
  trip_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_mode && uv_trip) |=> (prot_mode && !dsg_fet && !asleep));
endmodule

bind cell_guard_seq cg_seq_chk u_cg_seq_chk (.*);

// File: tb/cell_guard_seq_bench.sv
module cell_guard_seq_bench;
  localparam int REL = 6;
  localparam int GAP = 4;
  localparam int WA  = 3;
  localparam int WB  = 5;
  localparam int PAD = 2;
  localparam int WIN = ((WA > WB) ? WA : WB) + PAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b1;
  logic wake_ok = 1'b0, cells_ok = 1'b0, chg_en = 1'b0, uv_trip = 1'b0;
  logic [2:0] mon_sel = 3'd0;
  logic wr_chg = 1'b0, wr_dsg = 1'b0, wr_data = 1'b0;
  logic chg_fet, dsg_fet, reg_en, spi_en, prot_mode, asleep, win_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit slow_tick = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  cell_guard_seq #(
    .REL_TICKS(REL), .GAP_TICKS(GAP), .WIN_A_TICKS(WA),
    .WIN_B_TICKS(WB), .WIN_PAD_TICKS(PAD), .MON_W(3)
  ) u_cell_guard_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wake_ok(wake_ok),
    .cells_ok(cells_ok), .chg_en(chg_en), .uv_trip(uv_trip), .mon_sel(mon_sel),
    .wr_chg(wr_chg), .wr_dsg(wr_dsg), .wr_data(wr_data),
    .chg_fet(chg_fet), .dsg_fet(dsg_fet), .reg_en(reg_en), .spi_en(spi_en),
    .prot_mode(prot_mode), .asleep(asleep), .win_busy(win_busy)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    ms_tick = slow_tick ? ((cyc % 3) == 0) : 1'b1;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model: 0 sleep, 1 window, 2 guarded, 3 normal
  int m_st, m_win, m_rel, m_ph, m_gap;
  bit m_cb, m_db;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_win = WIN; m_rel = REL; m_ph = 0; m_gap = GAP; m_cb = 0; m_db = 0;
    end else begin
      if (m_st >= 2) begin
        if (wr_chg) m_cb = wr_data;
        if (wr_dsg) m_db = wr_data;
      end
      case (m_st)
        0: begin
          m_win = WIN; m_rel = REL; m_ph = 0; m_gap = GAP;
          if (wake_ok) m_st = 1;
        end
        1: begin
          m_rel = REL; m_ph = 0; m_gap = GAP;
          if (!wake_ok) m_st = 0;
          else if (m_win == 0) m_st = 2;
          else if (ms_tick) m_win = m_win - 1;
        end
        2: begin
          if (!wake_ok) m_st = 0;
          else if (m_ph == 0) begin
            if (!cells_ok) m_rel = REL;
            else if (m_rel == 0) begin
              if (mon_sel != 0) m_st = 3;
              else begin m_ph = 1; m_gap = GAP; end
            end else if (ms_tick) m_rel = m_rel - 1;
          end else begin
            if (m_gap == 0) begin
              if (cells_ok) m_st = 3;
              else begin m_ph = 0; m_rel = REL; end
            end else if (ms_tick) m_gap = m_gap - 1;
          end
        end
        default: begin
          m_rel = REL; m_ph = 0; m_gap = GAP;
          if (uv_trip) m_st = 2;
        end
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R1", "model reg_en", reg_en, m_st != 0);
      chk("R2", "model spi_en", spi_en, m_st != 0);
      chk("R3", "model win_busy", win_busy, m_st == 1);
      chk("R8", "model asleep", asleep, m_st == 0);
      chk("R6", "model prot_mode", prot_mode, m_st != 3);
      chk("R10", "model chg_fet", chg_fet, m_cb && chg_en && (m_st >= 2));
      chk("R4", "model dsg_fet", dsg_fet, m_db && chg_en && (m_st == 3));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic sample;
    @(posedge clk); #1;
  endtask

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    sample();
    chk("R1", "reset asleep", asleep, 1);
    chk("R1", "reset reg_en", reg_en, 0);
    chk("R1", "reset spi_en", spi_en, 0);
    chk("R1", "reset prot_mode", prot_mode, 1);

    // Wake with cells low; attempt a write inside the window
    chg_en = 1'b1; mon_sel = 3'd1;
    @(negedge clk) wake_ok = 1'b1;
    @(negedge clk) begin wr_chg = 1'b1; wr_data = 1'b1; end
    @(negedge clk) wr_chg = 1'b0;
    n = 0;
    while (win_busy && n < 100) begin n++; sample(); end
    chk("R3", "chg_fet after window write", chg_fet, 0);
    chk("R2", "reg_en guarded", reg_en, 1);
    chk("R2", "prot_mode guarded", prot_mode, 1);

    @(negedge clk) begin wr_chg = 1'b1; wr_data = 1'b1; end
    @(negedge clk) begin wr_chg = 1'b0; wr_dsg = 1'b1; end
    @(negedge clk) wr_dsg = 1'b0;
    sample();
    chk("R10", "chg_fet after write", chg_fet, 1);
    chk("R4", "dsg_fet held off", dsg_fet, 0);

    // Partial count, drop, then full count
    @(negedge clk) cells_ok = 1'b1;
    repeat (3) @(negedge clk);
    cells_ok = 1'b0;
    @(negedge clk) cells_ok = 1'b1;
    n = 0; sample();
    while (prot_mode && n < 1000) begin n++; sample(); end
    chk("R5", "guarded cycles after reload", n, REL);
    chk("R6", "released prot_mode", prot_mode, 0);
    chk("R4", "dsg_fet after release", dsg_fet, 1);
    chk("R10", "chg_fet kept on release", chg_fet, 1);

    @(negedge clk) wake_ok = 1'b0;
    repeat (3) sample();
    chk("R9", "normal ignores low supply", prot_mode, 0);
    chk("R9", "not asleep", asleep, 0);

    @(negedge clk) chg_en = 1'b0;
    sample();
    chk("R11", "chg_fet gated", chg_fet, 0);
    chk("R11", "dsg_fet gated", dsg_fet, 0);
    @(negedge clk) chg_en = 1'b1;
    sample();
    chk("R11", "chg_fet restored", chg_fet, 1);

    @(negedge clk) uv_trip = 1'b1;
    sample();
    chk("R12", "trip prot_mode", prot_mode, 1);
    chk("R12", "trip dsg_fet", dsg_fet, 0);
    @(negedge clk) uv_trip = 1'b0;
    sample();
    chk("R8", "guard sleeps", asleep, 1);
    chk("R1", "sleep spi_en", spi_en, 0);
    chk("R1", "sleep chg_fet", chg_fet, 0);

    // Two-sample recovery, tick held high
    @(negedge clk) begin wake_ok = 1'b1; mon_sel = 3'd0; cells_ok = 1'b1; end
    n = 0; sample();
    while (win_busy && n < 100) begin n++; sample(); end
    chk("R3", "window length", n, WIN + 1);
    n = 0;
    while (prot_mode && n < 1000) begin n++; sample(); end
    chk("R7", "two-sample guarded cycles", n, REL + GAP + 2);

    // Failing second sample
    @(negedge clk) uv_trip = 1'b1;
    @(negedge clk) uv_trip = 1'b0;
    repeat (REL + 1 + GAP) @(negedge clk);
    cells_ok = 1'b0;
    @(negedge clk) cells_ok = 1'b1;
    sample();
    chk("R7", "failed second sample keeps guard", prot_mode, 1);
    n = 0;
    while (prot_mode && n < 1000) begin n++; sample(); end
    chk("R7", "eventual release", prot_mode, 0);

    // Sparse ticks
    @(negedge clk) begin slow_tick = 1'b1; uv_trip = 1'b1; end
    @(negedge clk) uv_trip = 1'b0;
    n = 0;
    while (prot_mode && n < 2000) begin n++; sample(); end
    chk("R5", "release under sparse ticks", prot_mode, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule